// File: doc/BRIEF.md
# Calendar Clock with Deferred Write Commit

This block keeps wall-clock time and a calendar date. It advances once for every pulse on a one-second tick input. Software reaches it through a small 32-bit register window with three words: a control word, a date word and a time word. Reads of the date and time words always return the live counters. Because the counters keep moving between accesses, software that needs a consistent pair reads both words twice and compares them.

A write to the date or time word does not take effect at once. The written value is held, and a busy flag for that word shows in the control word. The held value is applied on the next tick, or after `COMMIT_DELAY` clock cycles if that comes first. The busy flag then drops, and software polls it before it trusts the new value. While a word is busy, further writes to that word are dropped.

The year is kept as a 6-bit offset from a base year. Software supplies the leap-year flag, and the hardware never computes it. Day, month and year rollover follow that flag.

Top module: `calendar_clock`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0, the time word (offset 0x8) reads 0, and the date word (offset 0x4) reads day 1, month 1, year offset 0 and leap flag 0, which is 0x00000101. A read of any other offset returns 0.
- R2: Field layout. The time word has seconds in [5:0], minutes in [13:8] and hours in [20:16]. The date word has day in [4:0], month in [11:8], year offset in [21:16] and the leap flag in bit 22. Without a tick or a commit, neither word changes.
- R3: A write to the time word sets control bit 8, and a write to the date word sets control bit 7. The live word keeps its old value until the commit.
- R4: A pending word commits on the first tick after the write, or on the `COMMIT_DELAY`-th clock edge after the write edge, whichever comes first. Its busy bit clears on that same edge.
- R5: A write to a word whose busy bit is set is ignored. The value that commits is the first one written.
- R6: A tick that arrives in a cycle where any word commits does not advance the counters.
- R7: Seconds and minutes wrap from 59 to 0 and carry onward. Hours wrap from 23 to 0 and carry into the day.
- R8: The day wraps to 1 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February when the leap flag is 0. When the day wraps, the month increments.
- R9: When the leap flag is 1, February runs to day 29 before the month rolls over to March.
- R10: Month 12 wraps to 1 and increments the year offset modulo 64. The leap flag is left unchanged.
- R11: Writes to the control word are ignored. Its busy bits can only be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_wr_i | input | 1 | Write strobe for the register window |
| bus_addr_i | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |

## Verification
The hardest situation to reach is the collision of a tick with a commit, because that tick must be consumed without advancing the counters. The bench reaches it by writing a word and then pulsing the tick while the word is still pending. It then reads both words and confirms that nothing moved. The year and leap rollovers need a state far from reset. The stimulus loads that state through the deferred write path, commits it with one tick, and triggers the rollover with a second tick.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

    localparam int WORD_W  = 32;
    localparam int SEC_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DAY_W   = 5;
    localparam int MON_W   = 4;
    localparam int YEAR_W  = 6;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [SEC_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } hms_t;

    typedef struct packed {
        logic              leap;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
    } ymd_t;

    localparam int HMS_W = $bits(hms_t);
    localparam int YMD_W = $bits(ymd_t);

    // last valid day of a month; out-of-range month codes behave as long months
    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic leap);
        logic [DAY_W-1:0] n;
        case (m)
            4'd2:                     n = leap ? DAY_W'(29) : DAY_W'(28);
            4'd4, 4'd6, 4'd9, 4'd11:  n = DAY_W'(30);
            default:                  n = DAY_W'(31);
        endcase
        return n;
    endfunction

    function automatic hms_t word_to_hms(input logic [WORD_W-1:0] w);
        hms_t r;
        r.sec  = w[5:0];
        r.min  = w[13:8];
        r.hour = w[20:16];
        return r;
    endfunction

    function automatic ymd_t word_to_ymd(input logic [WORD_W-1:0] w);
        ymd_t r;
        r.day   = w[4:0];
        r.month = w[11:8];
        r.year  = w[21:16];
        r.leap  = w[22];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] hms_to_word(input hms_t t);
        return {11'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
    endfunction

    function automatic logic [WORD_W-1:0] ymd_to_word(input ymd_t d);
        return {9'b0, d.leap, d.year, 4'b0, d.month, 3'b0, d.day};
    endfunction

endpackage

// File: rtl/calclk_commit_slot.sv
module calclk_commit_slot #(
    parameter int VAL_W = 17,
    parameter int DELAY = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [VAL_W-1:0] val_i,
    output logic             busy_o,
    output logic             commit_o,
    output logic [VAL_W-1:0] held_o
);

    localparam int CNT_W = $clog2(DELAY + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [VAL_W-1:0] held;
    } slot_t;

    slot_t s_d, s_q;

    initial begin
        if (DELAY < 1) $error("DELAY must be at least 1");
    end

    assign commit_o = s_q.busy && (tick_i || (s_q.cnt == CNT_W'(1)));
    assign busy_o   = s_q.busy;
    assign held_o   = s_q.held;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (commit_o) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end else if (wr_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(DELAY);
            s_d.held = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/calclk_engine.sv
module calclk_engine
    import calclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ld_time_i,
    input  hms_t time_i,
    input  logic ld_date_i,
    input  ymd_t date_i,
    output hms_t time_o,
    output ymd_t date_o
);

    typedef struct packed {
        hms_t t;
        ymd_t d;
    } cal_t;

    cal_t c_d, c_q;

    logic wrap_sec, wrap_min, wrap_hour, wrap_day, wrap_mon;

    always_comb begin
        wrap_sec  = c_q.t.sec  >= SEC_W'(59);
        wrap_min  = c_q.t.min  >= SEC_W'(59);
        wrap_hour = c_q.t.hour >= HOUR_W'(23);
        wrap_day  = c_q.d.day  >= month_len(c_q.d.month, c_q.d.leap);
        wrap_mon  = c_q.d.month >= MON_W'(12);

        c_d = c_q;
        if (ld_time_i || ld_date_i) begin
            if (ld_time_i) c_d.t = time_i;
            if (ld_date_i) c_d.d = date_i;
        end else if (tick_i) begin
            c_d.t.sec = wrap_sec ? '0 : c_q.t.sec + SEC_W'(1);
            if (wrap_sec) begin
                c_d.t.min = wrap_min ? '0 : c_q.t.min + SEC_W'(1);
                if (wrap_min) begin
                    c_d.t.hour = wrap_hour ? '0 : c_q.t.hour + HOUR_W'(1);
                    if (wrap_hour) begin
                        c_d.d.day = wrap_day ? DAY_W'(1) : c_q.d.day + DAY_W'(1);
                        if (wrap_day) begin
                            c_d.d.month = wrap_mon ? MON_W'(1) : c_q.d.month + MON_W'(1);
                            if (wrap_mon) begin
                                c_d.d.year = c_q.d.year + YEAR_W'(1);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.d.day   <= DAY_W'(1);
            c_q.d.month <= MON_W'(1);
        end else begin
            c_q <= c_d;
        end
    end

    assign time_o = c_q.t;
    assign date_o = c_q.d;

endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
    import calclk_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int COMMIT_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o
);

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] OFS_DATE = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] OFS_TIME = ADDR_W'(4'h8);
    localparam int BUSY_TIME_BIT = 8;
    localparam int BUSY_DATE_BIT = 7;

    logic wr_time, wr_date;
    logic busy_time, busy_date;
    logic commit_time, commit_date, commit_any;
    logic [HMS_W-1:0] held_time;
    logic [YMD_W-1:0] held_date;
    hms_t live_time;
    ymd_t live_date;
    logic [WORD_W-1:0] time_word, date_word, ctrl_word;

    assign wr_time    = bus_wr_i && (bus_addr_i == OFS_TIME);
    assign wr_date    = bus_wr_i && (bus_addr_i == OFS_DATE);
    assign commit_any = commit_time || commit_date;

    calclk_commit_slot #(.VAL_W(HMS_W), .DELAY(COMMIT_DELAY)) u_slot_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .wr_i     (wr_time),
        .val_i    (HMS_W'(word_to_hms(bus_wdata_i))),
        .busy_o   (busy_time),
        .commit_o (commit_time),
        .held_o   (held_time)
    );

    calclk_commit_slot #(.VAL_W(YMD_W), .DELAY(COMMIT_DELAY)) u_slot_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .wr_i     (wr_date),
        .val_i    (YMD_W'(word_to_ymd(bus_wdata_i))),
        .busy_o   (busy_date),
        .commit_o (commit_date),
        .held_o   (held_date)
    );

    calclk_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .ld_time_i (commit_time),
        .time_i    (hms_t'(held_time)),
        .ld_date_i (commit_date),
        .date_i    (ymd_t'(held_date)),
        .time_o    (live_time),
        .date_o    (live_date)
    );

    always_comb begin
        time_word = hms_to_word(live_time);
        date_word = ymd_to_word(live_date);
        ctrl_word = '0;
        ctrl_word[BUSY_TIME_BIT] = busy_time;
        ctrl_word[BUSY_DATE_BIT] = busy_date;
        case (bus_addr_i)
            OFS_CTRL: bus_rdata_o = ctrl_word;
            OFS_DATE: bus_rdata_o = date_word;
            OFS_TIME: bus_rdata_o = time_word;
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/calclk_chk.sv
module calclk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        wr_time,
    input logic        wr_date,
    input logic        busy_time,
    input logic        busy_date,
    input logic        commit_any,
    input logic [31:0] time_word,
    input logic [31:0] date_word
);

    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !commit_any) |=> ($stable(time_word) && $stable(date_word)));

    // R3
    time_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_time && !busy_time) |=> busy_time);

    // R3
    date_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_date && !busy_date) |=> busy_date);

    // R4
    tick_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (busy_time || busy_date)) |=> (!busy_time && !busy_date));

    // R7
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !commit_any && time_word[5:0] == 6'd59) |=> (time_word[5:0] == 6'd0));

    // R10
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !commit_any && time_word == 32'h0017_3B3B
         && date_word[11:8] == 4'd12 && date_word[4:0] == 5'd31)
        |=> (date_word[11:8] == 4'd1 && date_word[22] == $past(date_word[22])));

endmodule

bind calendar_clock calclk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_time    (wr_time),
    .wr_date    (wr_date),
    .busy_time  (busy_time),
    .busy_date  (busy_date),
    .commit_any (commit_any),
    .time_word  (time_word),
    .date_word  (date_word)
);

// File: tb/tb_calendar_clock.sv
module tb_calendar_clock;

    localparam int ADDR_W = 4;
    localparam int DELAY  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic              bus_wr_i = 1'b0;
    logic [ADDR_W-1:0] bus_addr_i = '0;
    logic [31:0]       bus_wdata_i = '0;
    logic [31:0]       bus_rdata_o;

    always #2 clk = ~clk;

    calendar_clock #(.ADDR_W(ADDR_W), .COMMIT_DELAY(DELAY)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [31:0]       exp;
        string             tag;
    } item_t;

    item_t sb_q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    function automatic logic [31:0] tw(int h, int m, int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dw(int leap, int y, int mo, int d);
        return (32'(leap) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (bus_rdata_o !== it.exp) begin
                    bad++;
                    $display("FAIL %s addr=%0h actual=%08h expected=%08h",
                             it.tag, it.addr, bus_rdata_o, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                             input string tag);
        item_t it;
        @(negedge clk);
        bus_addr_i = a;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i    = 1'b1;
        bus_addr_i  = a;
        bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // load both words and commit them with a single tick
    task automatic set_moment(input logic [31:0] d, input logic [31:0] t);
        bus_write(4'h8, t);
        bus_write(4'h4, d);
        pulse_tick();
    endtask

    task automatic finish_run();
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset state and unmapped offset
        expect_rd(4'h0, 32'h0, "R1 ctrl reset");
        expect_rd(4'h4, dw(0, 0, 1, 1), "R1 date reset");
        expect_rd(4'h8, 32'h0, "R1 time reset");
        expect_rd(4'hC, 32'h0, "R1 unmapped read");

        // R2 no change without tick
        idle(5);
        expect_rd(4'h8, 32'h0, "R2 time holds");
        expect_rd(4'h4, dw(0, 0, 1, 1), "R2 date holds");

        // R3 busy bit 8 and deferred apply
        bus_write(4'h8, tw(23, 59, 59));
        expect_rd(4'h0, 32'h100, "R3 time busy bit");
        expect_rd(4'h8, 32'h0, "R3 time not yet applied");
        // R5 second write while busy is dropped
        bus_write(4'h8, tw(1, 2, 3));
        expect_rd(4'h0, 32'h100, "R5 still busy");
        // R4 delay commit
        idle(DELAY + 2);
        expect_rd(4'h0, 32'h0, "R4 busy cleared after delay");
        expect_rd(4'h8, tw(23, 59, 59), "R5 first value committed");

        // R3 date busy bit 7, R4 tick commit, R6 tick consumed
        bus_write(4'h4, dw(0, 5, 2, 28));
        expect_rd(4'h0, 32'h80, "R3 date busy bit");
        pulse_tick();
        expect_rd(4'h0, 32'h0, "R4 busy cleared by tick");
        expect_rd(4'h4, dw(0, 5, 2, 28), "R4 date committed on tick");
        expect_rd(4'h8, tw(23, 59, 59), "R6 commit tick does not advance");

        // R8 non-leap February end
        pulse_tick();
        expect_rd(4'h8, 32'h0, "R7 hour wrap to midnight");
        expect_rd(4'h4, dw(0, 5, 3, 1), "R8 Feb 28 to Mar 1");

        // R7 seconds and minutes
        set_moment(dw(0, 5, 3, 1), tw(0, 0, 58));
        pulse_tick();
        expect_rd(4'h8, tw(0, 0, 59), "R7 seconds count");
        pulse_tick();
        expect_rd(4'h8, tw(0, 1, 0), "R7 seconds wrap into minute");
        set_moment(dw(0, 5, 3, 1), tw(4, 59, 59));
        pulse_tick();
        expect_rd(4'h8, tw(5, 0, 0), "R7 minutes wrap into hour");
        expect_rd(4'h4, dw(0, 5, 3, 1), "R7 no day carry before 24h");

        // R9 leap February
        set_moment(dw(1, 6, 2, 28), tw(23, 59, 59));
        pulse_tick();
        expect_rd(4'h4, dw(1, 6, 2, 29), "R9 leap Feb 29");
        bus_write(4'h8, tw(23, 59, 59));
        pulse_tick();
        pulse_tick();
        expect_rd(4'h4, dw(1, 6, 3, 1), "R9 leap Feb 29 to Mar 1");

        // R8 month lengths
        set_moment(dw(0, 7, 4, 30), tw(23, 59, 59));
        pulse_tick();
        expect_rd(4'h4, dw(0, 7, 5, 1), "R8 Apr 30 to May 1");
        set_moment(dw(0, 7, 1, 30), tw(23, 59, 59));
        pulse_tick();
        expect_rd(4'h4, dw(0, 7, 1, 31), "R8 Jan 30 to Jan 31");
        set_moment(dw(0, 7, 1, 31), tw(23, 59, 59));
        pulse_tick();
        expect_rd(4'h4, dw(0, 7, 2, 1), "R8 Jan 31 to Feb 1");

        // R10 year wrap keeps leap flag
        set_moment(dw(1, 63, 12, 31), tw(23, 59, 59));
        pulse_tick();
        expect_rd(4'h4, dw(1, 0, 1, 1), "R10 year offset wraps");
        set_moment(dw(0, 9, 12, 31), tw(23, 59, 59));
        pulse_tick();
        expect_rd(4'h4, dw(0, 10, 1, 1), "R10 year increments");

        // R11 control writes ignored
        bus_write(4'h0, 32'hFFFF_FFFF);
        expect_rd(4'h0, 32'h0, "R11 control write ignored");
        expect_rd(4'h4, dw(0, 10, 1, 1), "R11 date untouched");
        expect_rd(4'h8, 32'h0, "R11 time untouched");
        bus_write(4'h8, tw(1, 1, 1));
        bus_write(4'h4, dw(0, 1, 1, 1));
        expect_rd(4'h0, 32'h180, "R3 both busy bits");
        bus_write(4'h0, 32'h0);
        expect_rd(4'h0, 32'h180, "R11 busy bits not cleared by write");

        done = 1;
        finish_run();
    end

endmodule